// File: doc/BRIEF.md
# Asynchronous Bus Write-Cycle Master

This block is the master side of one write transfer on an asynchronous, 68k-style bus. A client presents an address, a data word, an operand size and a function code with a request. The block latches them and steps through six bus states. It drives the address phase and direction, raises the address strobe, puts the data word on the bus and raises the data strobe. It then waits for the slave's acknowledge before it drops both strobes and gives up the data bus.

Each bus state lasts one period of `clk`, so `clk` runs at the bus state rate, which is twice the system clock. The two DSACK inputs pass through a two-flop synchroniser before the state machine looks at them. A low level on either bit counts as an acknowledge. While no acknowledge has arrived, the master repeats a wait state. A new transfer cannot start until both acknowledge bits have been seen high again. The data bus is given as a value and an output enable so that the pad ring can build the tri-state driver.

Top module: `async_write_master`

## Requirements
- R1: While reset is applied and right after it, `as_n`, `ds_n` and `bus_rw` are high, and `data_oe` and `done` are low.
- R2: A transfer starts only from idle, with `req` high and both synchronised DSACK bits high. At that edge the block latches `req_addr`, `req_data`, `req_siz` and `req_fc`. Later changes to these inputs do not affect the running transfer.
- R3: In the first clock of a transfer (S0), `bus_rw` is low (0 = write, 1 = read/idle) and `bus_addr`, `bus_fc` and `bus_siz` carry the latched values. `as_n` goes low in the second clock (S1) and stays low through the last wait clock.
- R4: `data_oe` goes high in the third clock (S2) and stays high through the final clock (S5). `data_o` carries the latched data word.
- R5: `ds_n` goes low in the fourth clock (S3), which is after `as_n` and `data_oe`. `ds_n` is never low while `as_n` is high.
- R6: Either DSACK bit low is an acknowledge (`2'b00`, `2'b01` and `2'b10` all qualify). If the slave drives the acknowledge at the d-th falling clock edge after DS is first seen low (d = 0 for the first), `ds_n` stays low for d+3 clocks, because of the two synchroniser flops and the wait state.
- R7: In the final clock (S5), `done` is high for exactly one clock, `as_n` and `ds_n` are high, and `data_oe` is still high. In the next clock `bus_rw` is high and `data_oe` is low.
- R8: A transfer keeps `bus_rw` low for d+7 clocks, with d as in R6.
- R9: If `req` is held high, the next transfer's first clock appears exactly three clocks after the slave returns both DSACK bits high. Until then `bus_rw` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus state clock, one S-state per period |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request for a write transfer |
| req_addr | input | AW | Address for the transfer |
| req_data | input | DW | Data word to write |
| req_siz | input | 2 | Operand size code |
| req_fc | input | 3 | Function code |
| dsack_n | input | 2 | Slave acknowledge, active low, asynchronous |
| bus_addr | output | AW | Bus address |
| bus_fc | output | 3 | Bus function code |
| bus_siz | output | 2 | Bus size code |
| bus_rw | output | 1 | Direction, 0 during a write, 1 otherwise |
| as_n | output | 1 | Address strobe, active low |
| ds_n | output | 1 | Data strobe, active low |
| data_o | output | DW | Data bus value |
| data_oe | output | 1 | Data bus drive enable |
| done | output | 1 | One-clock pulse in the final state |

## Verification
The bench uses the default widths: a 24-bit address and a 16-bit data word. With these, every address and data bit can be checked against what the slave model latches, and the inputs are inverted mid-transfer to show they are ignored. A slave model with an adjustable acknowledge delay and release delay exercises the wait state over several lengths. It also drives each single-bit acknowledge pattern and holds DSACK long enough to show that a back-to-back request is held off.

// File: rtl/async_write_master.sv
module async_write_master #(
  parameter int AW = 24,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  input  logic [1:0]    req_siz,
  input  logic [2:0]    req_fc,
  input  logic [1:0]    dsack_n,
  output logic [AW-1:0] bus_addr,
  output logic [2:0]    bus_fc,
  output logic [1:0]    bus_siz,
  output logic          bus_rw,
  output logic          as_n,
  output logic          ds_n,
  output logic [DW-1:0] data_o,
  output logic          data_oe,
  output logic          done
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_S0, ST_S1, ST_S2, ST_S3, ST_S4, ST_S5
  } st_t;

  st_t        st, st_nx;
  logic [1:0] sync1, sync2;
  logic       ack;

  assign ack = (sync2 != 2'b11);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= 2'b11;
      sync2 <= 2'b11;
    end else begin
      sync1 <= dsack_n;
      sync2 <= sync1;
    end
  end

  always_comb begin
    st_nx = st;
    case (st)
      ST_IDLE: if (req && !ack) st_nx = ST_S0;
      ST_S0:   st_nx = ST_S1;
      ST_S1:   st_nx = ST_S2;
      ST_S2:   st_nx = ST_S3;
      ST_S3:   st_nx = ack ? ST_S5 : ST_S4;
      ST_S4:   st_nx = ack ? ST_S5 : ST_S4;
      ST_S5:   st_nx = ST_IDLE;
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      bus_addr <= '0;
      bus_fc   <= '0;
      bus_siz  <= '0;
      data_o   <= '0;
    end else begin
      st <= st_nx;
      if (st == ST_IDLE && st_nx == ST_S0) begin
        bus_addr <= req_addr;
        bus_fc   <= req_fc;
        bus_siz  <= req_siz;
        data_o   <= req_data;
      end
    end
  end

  assign bus_rw  = (st == ST_IDLE);
  assign as_n    = !(st inside {ST_S1, ST_S2, ST_S3, ST_S4});
  assign ds_n    = !(st inside {ST_S3, ST_S4});
  assign data_oe = st inside {ST_S2, ST_S3, ST_S4, ST_S5};
  assign done    = (st == ST_S5);

  AST_DS_INSIDE_AS: assert property (@(posedge clk) disable iff (!rst_n)
    !ds_n |-> !as_n); // R5
  AST_OE_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> !bus_rw); // R4
  AST_DONE_STROBES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (as_n && ds_n && data_oe)); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_START_NEEDS_IDLE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_rw) |-> $past(sync2) == 2'b11); // R9
  AST_DS_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ds_n) |=> !ds_n); // R6
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rw && !$fell(bus_rw)) |-> $stable(bus_addr) && $stable(data_o)); // R2

endmodule

// File: tb/test_async_write_master.sv
module test_async_write_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [23:0] req_addr = '0;
  logic [15:0] req_data = '0;
  logic [1:0]  req_siz = '0;
  logic [2:0]  req_fc = '0;
  logic [1:0]  dsack_n = 2'b11;
  logic [23:0] bus_addr;
  logic [2:0]  bus_fc;
  logic [1:0]  bus_siz;
  logic        bus_rw, as_n, ds_n, data_oe, done;
  logic [15:0] data_o;

  int checks = 0;
  int bad = 0;
  bit finished = 0;

  async_write_master i_async_write_master (
    .clk(clk), .rst_n(rst_n), .req(req), .req_addr(req_addr),
    .req_data(req_data), .req_siz(req_siz), .req_fc(req_fc),
    .dsack_n(dsack_n), .bus_addr(bus_addr), .bus_fc(bus_fc),
    .bus_siz(bus_siz), .bus_rw(bus_rw), .as_n(as_n), .ds_n(ds_n),
    .data_o(data_o), .data_oe(data_oe), .done(done)
  );

  always #10 clk = ~clk;

  int          wait_d = 0, hold_h = 0, cnt = 0, hcnt = 0, ncnt = 0, rel_at = 0;
  logic [1:0]  ack_val = 2'b00;
  bit          acked = 0;
  logic [23:0] lat_addr;
  logic [15:0] lat_data;
  logic [2:0]  lat_fc;
  logic [1:0]  lat_siz;
  logic        lat_oe;

  always @(negedge clk) begin
    ncnt = ncnt + 1;
    if (acked && as_n) begin
      if (hcnt == hold_h) begin
        dsack_n = 2'b11; acked = 0; cnt = 0; hcnt = 0; rel_at = ncnt;
      end else hcnt = hcnt + 1;
    end else if (!acked && !ds_n) begin
      if (cnt == wait_d) begin
        dsack_n = ack_val; acked = 1;
        lat_addr = bus_addr; lat_data = data_o; lat_fc = bus_fc;
        lat_siz = bus_siz; lat_oe = data_oe;
      end else cnt = cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req_tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req_tag, act, exp);
    end
  endtask

  task automatic t_reset;
    rst_n = 0;
    repeat (3) @(negedge clk);
    #1;
    chk(as_n && ds_n, "R1 strobes high in reset", {as_n, ds_n}, 3);
    chk(bus_rw == 1, "R1 rw high in reset", bus_rw, 1);
    chk(!data_oe && !done, "R1 oe/done low in reset", {data_oe, done}, 0);
    rst_n = 1;
    @(negedge clk); #1;
    chk(bus_rw && as_n && !data_oe && !done, "R1 idle after reset",
        {bus_rw, as_n, data_oe, done}, 4'b1100);
  endtask

  task automatic t_write(input logic [23:0] a, input logic [15:0] d,
                         input logic [1:0] s, input logic [2:0] f,
                         input int w, input int h, input logic [1:0] av);
    int idx = 0, f_as = -1, f_oe = -1, f_ds = -1, ds_c = 0, as_c = 0;
    int dn_c = 0, dn_i = -1, oe_dn = 0;
    wait_d = w; hold_h = h; ack_val = av;
    req_addr = a; req_data = d; req_siz = s; req_fc = f; req = 1;
    do begin @(negedge clk); #1; end while (bus_rw);
    req = 0;
    req_addr = ~a; req_data = ~d; req_siz = ~s; req_fc = ~f;
    chk(bus_addr == a && bus_fc == f && bus_siz == s, "R3 address phase in S0",
        bus_addr, a);
    while (!bus_rw) begin
      if (!as_n) begin as_c++; if (f_as < 0) f_as = idx; end
      if (data_oe && f_oe < 0) f_oe = idx;
      if (!ds_n) begin ds_c++; if (f_ds < 0) f_ds = idx; end
      if (done) begin dn_c++; dn_i = idx; oe_dn = data_oe; end
      idx++;
      @(negedge clk); #1;
    end
    chk(f_as == 1, "R3 AS in S1", f_as, 1);
    chk(as_c == w + 5, "R3 AS width", as_c, w + 5);
    chk(f_oe == 2, "R4 data drive in S2", f_oe, 2);
    chk(f_ds == 3, "R5 DS in S3", f_ds, 3);
    chk(ds_c == w + 3, "R6 DS width vs ack delay", ds_c, w + 3);
    chk(dn_c == 1 && dn_i == w + 6, "R7 done single in S5", dn_i, w + 6);
    chk(oe_dn == 1, "R7 data held in S5", oe_dn, 1);
    chk(idx == w + 7, "R8 cycle length", idx, w + 7);
    chk(!data_oe && as_n && ds_n, "R7 bus released after S5", data_oe, 0);
    chk(lat_data == d && lat_oe, "R4 slave data", lat_data, d);
    chk(lat_addr == a && lat_fc == f && lat_siz == s, "R2 latched request kept",
        lat_addr, a);
  endtask

  task automatic t_b2b(input int h);
    req = 1;
    do begin @(negedge clk); #1; end while (bus_rw);
    chk(ncnt - rel_at == 3, "R9 restart after DSACK release", ncnt - rel_at, 3);
    req = 0;
    while (!bus_rw) begin @(negedge clk); #1; end
    repeat (h + 6) @(negedge clk);
  endtask

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
          chk(0, "watchdog", 0, 1);
          $display("test done: total=%0d bad=%0d", checks, bad);
          $finish;
        end
      end
    join_none
    t_reset();
    t_write(24'hA5C3F1, 16'h1234, 2'b10, 3'b101, 0, 0, 2'b00);
    repeat (4) @(negedge clk);
    t_write(24'h0F00FF, 16'hBEEF, 2'b01, 3'b010, 2, 1, 2'b10);
    repeat (6) @(negedge clk);
    t_write(24'hFFFFFF, 16'h8001, 2'b00, 3'b111, 5, 0, 2'b01);
    t_b2b(0);
    t_write(24'h123456, 16'h55AA, 2'b11, 3'b001, 1, 6, 2'b00);
    t_b2b(6);
    finished = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule